// File: doc/BRIEF.md
# Masked Change-of-State Interrupt Controller

This block watches sixteen input lines for changes in level and turns them into a single level-sensitive interrupt request. Twelve lines are general I/O pins, divided into four channel groups of three pins each (pins 3g to 3g+2 form group g). The other four are channel-group lines, one for each group. Each line has a direction bit and a mask bit. Each group also has a group mask bit, and what that bit does depends on the configuration mode. All inputs pass through a two-stage synchronizer before any change is detected.

A line can be set to report a change at once, or it can be put through a persistency check. Under the persistency check, a new level is accepted only after it has held for more than a programmed number of prescaler ticks. If the line bounces back to its old level, the count starts again. Each accepted change on a line that is configured as an input sets a sticky status bit. The interrupt request is the OR of the sticky bits whose lines are currently enabled. Software clears status bits by writing ones through the clear strobe.

The block has no streaming data path. Every pin is a plain control or status level, so no valid/ready handshake or back-pressure rule applies.

Top module: `coschg_irq`

## Requirements
- R1: After reset is released, `status` is zero and `irq` is low. A line level that is already present while reset is released is taken as the reference level and is not reported as a change.
- R2: A line configured as an input, with a per-line mask bit of 0, raises `irq` on both a rising and a falling change. With a mask bit of 1 the line does not raise `irq`.
- R3: A line whose direction bit is 1 (output) never sets its status bit and never raises `irq`, whatever its mask bit is.
- R4: Without the persistency check, a change on an input sets its status bit on the third rising clock edge after the input changes. The bit is still clear after the second edge.
- R5: With the persistency check on and a time of T, a change is accepted on the (T+1)th tick edge counted while the new level holds. It is not accepted after only T ticks.
- R6: If a line under the persistency check returns to its reference level before the change is accepted, its tick count restarts. A later change needs the full T+1 ticks again.
- R7: When `dyn_mode` is 1, a group mask bit of 1 blocks `irq` from every I/O pin of that group, and the channel-group lines never set status. When the group mask bit is 0, each pin follows its own mask.
- R8: When `dyn_mode` is 0, group mask bit g masks only the channel-group line g, which is status bit 12+g. I/O pins ignore the group masks.
- R9: `status` bits 11:0 hold the I/O pins and bits 15:12 hold the group lines. A bit is set by an accepted change on an input line even when that line is masked, and it stays set until cleared. Writing a 1 to a bit with `clr_we` clears it. If a set and a clear reach the same bit in the same cycle, the set wins. `irq` is the OR of the status bits of the enabled lines, so unmasking a line whose bit is already set raises `irq` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_in | input | 12 | I/O pin levels (asynchronous) |
| io_dir_out | input | 12 | 1 = pin is an output and never interrupts |
| io_mask | input | 12 | Per-pin interrupt mask, 1 = masked |
| io_pchk | input | 12 | 1 = pin uses the persistency check |
| grp_in | input | 4 | Channel-group line levels (asynchronous) |
| grp_dir_out | input | 4 | 1 = group line is an output |
| grp_pchk | input | 4 | 1 = group line uses the persistency check |
| grp_mask | input | 4 | Group mask bits, meaning set by `dyn_mode` |
| dyn_mode | input | 1 | 1 = dynamic configuration, 0 = static configuration |
| pchk_time | input | 8 | Persistency time T, in ticks |
| tick | input | 1 | Prescaler enable, one cycle wide |
| clr_we | input | 1 | Clear strobe for the status bits |
| clr_data | input | 16 | Write-one-to-clear pattern |
| status | output | 16 | Sticky change status |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach from the ports is a bounce under the persistency check. The restart of the tick count is visible only through the timing of a later acceptance. The stimulus moves a line to its new level and delivers fewer than T+1 ticks. It then returns the line to its old level long enough for the synchronizer to settle, and moves it again. The check confirms that T ticks after the second move are still not enough, which would not hold if the first partial count had been kept. A second hard case is a set and a clear reaching the same bit in the same cycle. To reach it, the clear strobe is timed against the third edge after an input change.

// File: rtl/coschg_pkg.sv
package coschg_pkg;
  localparam int unsigned IO_LINES   = 12;
  localparam int unsigned GRP_LINES  = 4;
  localparam int unsigned TIME_W     = 8;
  localparam int unsigned SYNC_DEPTH = 2;
  typedef enum logic { CFG_STATIC = 1'b0, CFG_DYNAMIC = 1'b1 } cfg_mode_e;
endpackage

// File: rtl/coschg_sync.sv
module coschg_sync #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  genvar s;
  generate
    for (s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/coschg_line.sv
module coschg_line #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          din,
  input  logic          pchk,
  input  logic [TW-1:0] limit,
  input  logic          tick,
  output logic          accept
);
  logic          ref_lvl;
  logic [TW-1:0] cnt;
  logic          differs;

  assign differs = din != ref_lvl;
  assign accept  = armed && differs && (!pchk || (tick && cnt >= limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_lvl <= 1'b0;
      cnt     <= '0;
    end else if (!armed) begin
      ref_lvl <= din;
      cnt     <= '0;
    end else if (accept) begin
      ref_lvl <= din;
      cnt     <= '0;
    end else if (!differs || !pchk) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/coschg_irq.sv
module coschg_irq
  import coschg_pkg::*;
#(
  parameter int unsigned N_IO  = IO_LINES,
  parameter int unsigned N_GRP = GRP_LINES,
  parameter int unsigned TW    = TIME_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_IO-1:0]       io_in,
  input  logic [N_IO-1:0]       io_dir_out,
  input  logic [N_IO-1:0]       io_mask,
  input  logic [N_IO-1:0]       io_pchk,
  input  logic [N_GRP-1:0]      grp_in,
  input  logic [N_GRP-1:0]      grp_dir_out,
  input  logic [N_GRP-1:0]      grp_pchk,
  input  logic [N_GRP-1:0]      grp_mask,
  input  logic                  dyn_mode,
  input  logic [TW-1:0]         pchk_time,
  input  logic                  tick,
  input  logic                  clr_we,
  input  logic [N_IO+N_GRP-1:0] clr_data,
  output logic [N_IO+N_GRP-1:0] status,
  output logic                  irq
);
  localparam int unsigned NL  = N_IO + N_GRP;
  localparam int unsigned LPG = N_IO / N_GRP;

  logic [NL-1:0] raw, synced, pchk_all, accept;
  logic [NL-1:0] src_en, irq_en, clr_mask;
  logic [N_IO-1:0] grp_blk;
  logic [1:0] warm;
  logic armed;

  assign raw      = {grp_in, io_in};
  assign pchk_all = {grp_pchk, io_pchk};

  coschg_sync #(.W(NL), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  // Hold the detectors in reference-load until the synchronizer carries real levels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 1'b1;
  end
  assign armed = warm == 2'd3;

  genvar i;
  generate
    for (i = 0; i < NL; i++) begin : g_line
      coschg_line #(.TW(TW)) u_line (
        .clk(clk), .rst_n(rst_n), .armed(armed), .din(synced[i]),
        .pchk(pchk_all[i]), .limit(pchk_time), .tick(tick),
        .accept(accept[i])
      );
    end
    for (i = 0; i < N_IO; i++) begin : g_blk
      assign grp_blk[i] = (dyn_mode == CFG_DYNAMIC) && grp_mask[i / LPG];
    end
  endgenerate

  assign src_en = {~grp_dir_out & {N_GRP{dyn_mode == CFG_STATIC}}, ~io_dir_out};
  assign irq_en = src_en & {~grp_mask, ~io_mask & ~grp_blk};
  assign clr_mask = clr_we ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else status <= (status & ~clr_mask) | (accept & src_en);
  end

  assign irq = |(status & irq_en);
endmodule

// File: rtl/coschg_irq_chk.sv
module coschg_irq_chk #(
  parameter int unsigned NL = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [11:0]   io_dir_out,
  input logic [11:0]   io_mask,
  input logic [11:0]   io_pchk,
  input logic [3:0]    grp_dir_out,
  input logic [3:0]    grp_pchk,
  input logic [3:0]    grp_mask,
  input logic          tick,
  input logic          clr_we,
  input logic [NL-1:0] status,
  input logic          irq
);
  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(status) & ~status)) |-> $past(clr_we));

  // R3
  out_dir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & $past({grp_dir_out, io_dir_out})) == '0));

  // R2
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&io_mask) && (&grp_mask)) |-> !irq);

  // R5
  pchk_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & ~$past(status) & $past({grp_pchk, io_pchk}))) |-> $past(tick));
endmodule

bind coschg_irq coschg_irq_chk #(.NL(16)) u_chk (.*);

// File: tb/test_coschg_irq.sv
module test_coschg_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] io_in = 12'h0A5, io_dir_out = '0, io_mask = '1, io_pchk = '0;
  logic [3:0] grp_in = '0, grp_dir_out = '0, grp_pchk = '0, grp_mask = '1;
  logic dyn_mode = 1'b0, tick = 1'b0, clr_we = 1'b0;
  logic [7:0] pchk_time = '0;
  logic [15:0] clr_data = '0;
  logic [15:0] status;
  logic irq;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  coschg_irq i_coschg_irq (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    @(negedge clk); clr_we = 1'b1; clr_data = '1;
    @(negedge clk); clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic pulse_tick(int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    edges(6);
    chk("R1 status after reset", status, 16'h0);
    chk("R1 irq after reset", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_immediate();
    io_mask = 12'hFFE;
    @(negedge clk); io_in[1] = 1'b1; io_in[0] = 1'b0;
    edges(2);
    chk("R4 not yet after two edges", status, 16'h0);
    edges(1);
    chk("R4 set on third edge (falling change)", status, 16'h0003);
    chk("R2 irq on unmasked fall", {15'h0, irq}, 16'h1);
    clear_all();
    chk("R9 cleared by write-one", status, 16'h0);
    @(negedge clk); io_in[0] = 1'b1;
    edges(4);
    chk("R2 irq on unmasked rise", {15'h0, irq}, 16'h1);
    clear_all();
    @(negedge clk); io_in[1] = 1'b0;
    edges(4);
    chk("R9 masked change still sets status", status, 16'h0002);
    chk("R2 masked line gives no irq", {15'h0, irq}, 16'h0);
    @(negedge clk); io_mask[1] = 1'b0;
    #1 chk("R9 unmask raises irq at once", {15'h0, irq}, 16'h1);
    io_mask = '1;
    clear_all();
  endtask

  task automatic t_outdir();
    io_mask = '0; io_dir_out[3] = 1'b1;
    @(negedge clk); io_in[3] = ~io_in[3];
    edges(5);
    chk("R3 output pin sets nothing", status, 16'h0);
    chk("R3 output pin no irq", {15'h0, irq}, 16'h0);
    io_dir_out = '0; io_mask = '1;
    clear_all();
  endtask

  task automatic t_dynamic();
    dyn_mode = 1'b1; io_mask = '0; grp_mask = 4'b0010;
    @(negedge clk); io_in[4] = ~io_in[4]; grp_in[0] = ~grp_in[0];
    edges(5);
    chk("R7 group-masked pin and group line", {status[15:12], 7'h0, irq, status[11:8], status[3:0]}, {4'h0, 7'h0, 1'b0, 4'h0, 4'h0});
    chk("R7 blocked pin still latched", {15'h0, status[4]}, 16'h1);
    @(negedge clk); io_in[7] = ~io_in[7];
    edges(4);
    chk("R7 unblocked group irq", {15'h0, irq}, 16'h1);
    io_mask = '1; grp_mask = '1; dyn_mode = 1'b0;
    clear_all();
  endtask

  task automatic t_static();
    io_mask = '0; grp_mask = 4'b1011;
    @(negedge clk); io_in[5] = ~io_in[5];
    edges(4);
    chk("R8 pin ignores group mask", {status, 15'h0, irq}, {16'h0020, 15'h0, 1'b1});
    clear_all();
    io_mask = '1;
    @(negedge clk); grp_in[2] = 1'b1; grp_in[3] = 1'b1;
    edges(4);
    chk("R8 group line status bits", status, 16'hC000);
    chk("R8 unmasked group line irq", {15'h0, irq}, 16'h1);
    @(negedge clk); grp_mask = '1;
    #1 chk("R8 masked group line no irq", {15'h0, irq}, 16'h0);
    clear_all();
  endtask

  task automatic t_persist();
    io_mask = '0; io_pchk[6] = 1'b1; pchk_time = 8'd3;
    @(negedge clk); io_in[6] = ~io_in[6];
    edges(4);
    pulse_tick(3);
    chk("R5 not accepted after T ticks", status, 16'h0);
    pulse_tick(1);
    chk("R5 accepted on tick T+1", status, 16'h0040);
    clear_all();
    // bounce: partial count, return, move again
    @(negedge clk); io_in[6] = ~io_in[6];
    edges(4);
    pulse_tick(2);
    @(negedge clk); io_in[6] = ~io_in[6];
    edges(4);
    @(negedge clk); io_in[6] = ~io_in[6];
    edges(4);
    pulse_tick(3);
    chk("R6 count restarted after bounce", status, 16'h0);
    pulse_tick(1);
    chk("R6 accepted after full count", status, 16'h0040);
    io_pchk = '0; io_mask = '1;
    clear_all();
  endtask

  task automatic t_set_wins();
    @(negedge clk); io_in[8] = ~io_in[8];
    @(posedge clk); @(posedge clk);
    @(negedge clk); clr_we = 1'b1; clr_data = '1;
    @(negedge clk); clr_we = 1'b0; clr_data = '0;
    chk("R9 set beats same-cycle clear", status, 16'h0100);
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    edges(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_immediate();
    t_outdir();
    t_dynamic();
    t_static();
    t_persist();
    t_set_wins();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule